// File: doc/BRIEF.md
# Dual-Issue Arbiter with Operand-Fetch Budget

This block sits in front of three execution pipes in a shader core: a 32-bit floating-point pipe, a 32-bit integer pipe and a 16-bit floating-point pipe. Each thread in a pool offers at most one instruction, described by a ready flag and a two-bit class. Every cycle the arbiter issues up to two of these instructions, one per pipe. Each pipe uses its own rotating pointer to pick among the threads that want it.

The register cache can supply a fixed number of operand bits per cycle, 48 by default. A wide instruction needs 32 of those bits and a narrow one needs 16. Any pairing that includes the 16-bit pipe fits inside this budget. Pairing the 32-bit float pipe with the integer pipe needs 64 bits, so it overdraws the budget. That pairing is still allowed, but the overdraw is recorded as a debt. Cycles that consume less than the budget pay the debt back. When the debt is full, a contested cycle issues nothing to the two wide pipes. Under a steady load of that pairing alone, three pairs issue in every four cycles. Each throttled cycle is flagged on a pulse and counted in a 32-bit counter.

Issue decisions are combinational from the inputs and the registered state: the pointers, the debt, the alternation bit and the counter. The grant for a cycle is therefore visible in that same cycle, and the state moves on at the clock edge.

Top module: `dia_arbiter`

## Requirements
- R1: In any cycle at most two of the three issue-valid outputs are high.
- R2: A pipe's valid output is high only when the thread on its ID output is ready and has that pipe's class. Because each thread has a single class, two issues in one cycle always come from different threads.
- R3: Class encoding is 2'b00 for 32-bit float, 2'b01 for integer, 2'b10 for 16-bit float, and 2'b11 for no instruction. A thread of class 2'b11 is never issued, even when its ready flag is high.
- R4: Each pipe grants the first matching thread at or after its pointer, wrapping around modulo the thread count. After a grant, that pipe's pointer moves to the granted ID plus one, wrapping to zero. Pointers start at zero after reset.
- R5: When any thread of the 16-bit class is ready, the 16-bit pipe issues. Its partner slot goes to whichever wide pipe has a candidate. When both wide pipes have candidates, they alternate, starting with the 32-bit float pipe after reset.
- R6: When both wide pipes have candidates, no 16-bit thread is ready and the debt is at most budget minus 16, both wide pipes issue and the debt rises by 16.
- R7: After each cycle, the debt becomes max(0, debt + bits issued − 48), where a wide issue counts 32 bits and a narrow issue counts 16. Under a steady wide-pair-only load from zero debt, exactly 6 pairs issue in 8 cycles.
- R8: A cycle in which both wide pipes have candidates, no 16-bit thread is ready and the debt exceeds budget minus 16 is a throttled cycle. In a throttled cycle neither wide pipe issues and the stall pulse is high for that cycle only.
- R9: The stall counter is zero after reset. It increments by one at each clock edge that closes a throttled cycle.
- R10: After reset, with no thread ready, no valid output is high, the stall pulse is low and the counter reads zero.
- R11: When only one class has ready threads, that class's pipe issues every cycle, whatever the debt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_ready | input | NT | Per-thread instruction-ready flag |
| thr_class | input | 2*NT | Per-thread class, thread t in bits [2t+1:2t] |
| fp32_vld | output | 1 | 32-bit float pipe issue valid |
| fp32_tid | output | TW | Thread ID issued to the 32-bit float pipe |
| int_vld | output | 1 | Integer pipe issue valid |
| int_tid | output | TW | Thread ID issued to the integer pipe |
| h16_vld | output | 1 | 16-bit float pipe issue valid |
| h16_tid | output | TW | Thread ID issued to the 16-bit float pipe |
| stall_pulse | output | 1 | High in a throttled cycle |
| stall_count | output | 32 | Number of throttled cycles since reset |

## Verification
A corrupted pointer shows up in the same cycle as a wrong thread ID on the affected pipe's next contested grant. A wrong debt value is first visible at the next cycle where both wide pipes compete without a 16-bit candidate. There it shows as a throttle pulse in the wrong cycle, or as a missing pulse, so the 3-in-4 cadence drifts within four cycles. A wrong alternation bit swaps which wide pipe partners the 16-bit pipe on the next three-way contest. The reference model tracks pointers, debt, alternation and count independently, and every output is compared against it on every cycle.

// File: rtl/dia_pkg.sv
package dia_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // Pipe index doubles as the class code that selects it.
    typedef enum logic [1:0] {
        CLS_F32  = 2'd0,
        CLS_INT  = 2'd1,
        CLS_F16  = 2'd2,
        CLS_NONE = 2'd3
    } cls_e;

    localparam int NPIPE = 3;
    localparam int PIPE_F32 = 0;
    localparam int PIPE_INT = 1;
    localparam int PIPE_F16 = 2;
endpackage

// File: rtl/dia_rr_pick.sv
// Rotating first-match picker: lowest offset from ptr wins.
module dia_rr_pick #(
    parameter int NT = 8,
    parameter int TW = $clog2(NT)
) (
    input  logic [NT-1:0] req,
    input  logic [TW-1:0] ptr,
    output logic          gnt_vld,
    output logic [TW-1:0] gnt_id
);
    timeunit 1ns;
    timeprecision 1ps;

    always_comb begin
        gnt_vld = 1'b0;
        gnt_id  = '0;
        for (int k = NT - 1; k >= 0; k--) begin
            int s;
            logic [TW-1:0] idx;
            s = int'(ptr) + k;
            if (s >= NT) s = s - NT;
            idx = TW'(s);
            if (req[idx]) begin
                gnt_vld = 1'b1;
                gnt_id  = idx;
            end
        end
    end
endmodule

// File: rtl/dia_pair_policy.sv
// Decides which pipes issue given per-pipe candidates and the operand debt.
module dia_pair_policy #(
    parameter int WIDE   = 32,
    parameter int NARROW = 16,
    parameter int BUDGET = 48,
    parameter int DW     = $clog2(BUDGET + 1)
) (
    input  logic [2:0]    cand,
    input  logic [DW-1:0] debt_q,
    input  logic          alt_q,
    output logic [2:0]    grant,
    output logic [DW-1:0] debt_d,
    output logic          alt_d,
    output logic          throttle
);
    timeunit 1ns;
    timeprecision 1ps;
    import dia_pkg::*;

    localparam int OVER  = 2 * WIDE - BUDGET;
    localparam int LIMIT = BUDGET - OVER;

    always_comb begin
        int used;
        int sum;
        grant    = '0;
        throttle = 1'b0;
        alt_d    = alt_q;
        used     = 0;
        if (cand[PIPE_F16]) begin
            grant[PIPE_F16] = 1'b1;
            used = NARROW;
            if (cand[PIPE_F32] && cand[PIPE_INT]) begin
                if (alt_q) grant[PIPE_INT] = 1'b1;
                else       grant[PIPE_F32] = 1'b1;
                alt_d = !alt_q;
                used  = used + WIDE;
            end else if (cand[PIPE_F32]) begin
                grant[PIPE_F32] = 1'b1;
                used = used + WIDE;
            end else if (cand[PIPE_INT]) begin
                grant[PIPE_INT] = 1'b1;
                used = used + WIDE;
            end
        end else if (cand[PIPE_F32] && cand[PIPE_INT]) begin
            if (int'(debt_q) <= LIMIT) begin
                grant[PIPE_F32] = 1'b1;
                grant[PIPE_INT] = 1'b1;
                used = 2 * WIDE;
            end else begin
                throttle = 1'b1;
            end
        end else if (cand[PIPE_F32]) begin
            grant[PIPE_F32] = 1'b1;
            used = WIDE;
        end else if (cand[PIPE_INT]) begin
            grant[PIPE_INT] = 1'b1;
            used = WIDE;
        end
        sum = int'(debt_q) + used;
        debt_d = (sum > BUDGET) ? DW'(sum - BUDGET) : '0;
    end
endmodule

// File: rtl/dia_arbiter.sv
module dia_arbiter #(
    parameter int NT     = 8,   // thread count, at least 2
    parameter int WIDE   = 32,
    parameter int NARROW = 16,
    parameter int BUDGET = 48,
    parameter int CNT_W  = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NT-1:0]          thr_ready,
    input  logic [2*NT-1:0]        thr_class,
    output logic                   fp32_vld,
    output logic [$clog2(NT)-1:0]  fp32_tid,
    output logic                   int_vld,
    output logic [$clog2(NT)-1:0]  int_tid,
    output logic                   h16_vld,
    output logic [$clog2(NT)-1:0]  h16_tid,
    output logic                   stall_pulse,
    output logic [CNT_W-1:0]       stall_count
);
    timeunit 1ns;
    timeprecision 1ps;
    import dia_pkg::*;

    localparam int TW = $clog2(NT);
    localparam int DW = $clog2(BUDGET + 1);

    typedef struct packed {
        logic [NPIPE-1:0][TW-1:0] ptr;
        logic [DW-1:0]            debt;
        logic                     alt;
        logic [CNT_W-1:0]         cnt;
    } state_t;

    state_t state_d, state_q;

    logic [NPIPE-1:0][NT-1:0] req;
    logic [NPIPE-1:0]         cand;
    logic [NPIPE-1:0][TW-1:0] gid;
    logic [NPIPE-1:0]         grant;
    logic [DW-1:0]            debt_n;
    logic                     alt_n;
    logic                     throttle;

    for (genvar p = 0; p < NPIPE; p++) begin : g_pipe
        always_comb begin
            for (int t = 0; t < NT; t++) begin
                req[p][t] = thr_ready[t] && (thr_class[2*t +: 2] == 2'(p));
            end
        end
        dia_rr_pick #(.NT(NT), .TW(TW)) i_pick (
            .req     (req[p]),
            .ptr     (state_q.ptr[p]),
            .gnt_vld (cand[p]),
            .gnt_id  (gid[p])
        );
    end

    dia_pair_policy #(
        .WIDE(WIDE), .NARROW(NARROW), .BUDGET(BUDGET), .DW(DW)
    ) i_policy (
        .cand     (cand),
        .debt_q   (state_q.debt),
        .alt_q    (state_q.alt),
        .grant    (grant),
        .debt_d   (debt_n),
        .alt_d    (alt_n),
        .throttle (throttle)
    );

    always_comb begin
        state_d = state_q;
        for (int p = 0; p < NPIPE; p++) begin
            if (grant[p]) begin
                state_d.ptr[p] = (gid[p] == TW'(NT - 1)) ? '0 : gid[p] + 1'b1;
            end
        end
        state_d.debt = debt_n;
        state_d.alt  = alt_n;
        if (throttle) state_d.cnt = state_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign fp32_vld    = grant[PIPE_F32];
    assign fp32_tid    = gid[PIPE_F32];
    assign int_vld     = grant[PIPE_INT];
    assign int_tid     = gid[PIPE_INT];
    assign h16_vld     = grant[PIPE_F16];
    assign h16_tid     = gid[PIPE_F16];
    assign stall_pulse = throttle;
    assign stall_count = state_q.cnt;
endmodule

// File: rtl/dia_arbiter_chk.sv
module dia_arbiter_chk #(
    parameter int NT    = 8,
    parameter int CNT_W = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NT-1:0]         thr_ready,
    input logic [2*NT-1:0]       thr_class,
    input logic                  fp32_vld,
    input logic [$clog2(NT)-1:0] fp32_tid,
    input logic                  int_vld,
    input logic [$clog2(NT)-1:0] int_tid,
    input logic                  h16_vld,
    input logic [$clog2(NT)-1:0] h16_tid,
    input logic                  stall_pulse,
    input logic [CNT_W-1:0]      stall_count
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [2:0] has;
    always_comb begin
        has = '0;
        for (int t = 0; t < NT; t++) begin
            if (thr_ready[t] && thr_class[2*t +: 2] != 2'd3) has[thr_class[2*t +: 2]] = 1'b1;
        end
    end

    p_two_max_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({fp32_vld, int_vld, h16_vld}) <= 2);

    p_grant_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fp32_vld |-> (thr_ready[fp32_tid] && thr_class[2*fp32_tid +: 2] == 2'd0));

    p_grant_match_int_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int_vld |-> (thr_ready[int_tid] && thr_class[2*int_tid +: 2] == 2'd1));

    p_narrow_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        has[2] |-> (h16_vld && thr_class[2*h16_tid +: 2] == 2'd2));

    p_stall_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stall_pulse |-> (!fp32_vld && !int_vld));

    p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> stall_count == $past(stall_count) + CNT_W'($past(stall_pulse)));

    p_repaid_after_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stall_pulse |=> (!(has[0] && has[1] && !has[2]) || (fp32_vld && int_vld)));
endmodule

bind dia_arbiter dia_arbiter_chk #(.NT(NT), .CNT_W(CNT_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .thr_ready   (thr_ready),
    .thr_class   (thr_class),
    .fp32_vld    (fp32_vld),
    .fp32_tid    (fp32_tid),
    .int_vld     (int_vld),
    .int_tid     (int_tid),
    .h16_vld     (h16_vld),
    .h16_tid     (h16_tid),
    .stall_pulse (stall_pulse),
    .stall_count (stall_count)
);

// File: tb/test_dia_arbiter.sv
module test_dia_arbiter;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NT = 8;
    localparam int TW = $clog2(NT);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NT-1:0] rdy = '0;
    logic [2*NT-1:0] cls = '1;
    logic fp32_vld, int_vld, h16_vld, stall_pulse;
    logic [TW-1:0] fp32_tid, int_tid, h16_tid;
    logic [31:0] stall_count;

    always #4 clk = !clk;

    dia_arbiter #(.NT(NT)) i_dia_arbiter (
        .clk(clk), .rst_n(rst_n), .thr_ready(rdy), .thr_class(cls),
        .fp32_vld(fp32_vld), .fp32_tid(fp32_tid),
        .int_vld(int_vld), .int_tid(int_tid),
        .h16_vld(h16_vld), .h16_tid(h16_tid),
        .stall_pulse(stall_pulse), .stall_count(stall_count)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference model state
    int m_ptr[3];
    int m_debt = 0;
    int m_alt = 0;
    int m_cnt = 0;
    int e_v[3];
    int e_id[3];
    int e_stall;
    int n_debt, n_alt;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_eval();
        int pk[3];
        int used;
        for (int p = 0; p < 3; p++) begin
            pk[p] = -1;
            for (int k = 0; k < NT; k++) begin
                int t;
                t = (m_ptr[p] + k) % NT;
                if (pk[p] < 0 && rdy[t] && int'(cls[2*t +: 2]) == p) pk[p] = t;
            end
            e_v[p] = 0;
            e_id[p] = (pk[p] < 0) ? 0 : pk[p];
        end
        used = 0; e_stall = 0; n_alt = m_alt;
        if (pk[2] >= 0) begin
            e_v[2] = 1; used = 16;
            if (pk[0] >= 0 && pk[1] >= 0) begin
                e_v[m_alt ? 1 : 0] = 1; n_alt = 1 - m_alt; used += 32;
            end else if (pk[0] >= 0) begin e_v[0] = 1; used += 32; end
            else if (pk[1] >= 0) begin e_v[1] = 1; used += 32; end
        end else if (pk[0] >= 0 && pk[1] >= 0) begin
            if (m_debt <= 32) begin e_v[0] = 1; e_v[1] = 1; used = 64; end
            else e_stall = 1;
        end else if (pk[0] >= 0) begin e_v[0] = 1; used = 32; end
        else if (pk[1] >= 0) begin e_v[1] = 1; used = 32; end
        n_debt = m_debt + used - 48;
        if (n_debt < 0) n_debt = 0;
    endtask

    task automatic model_commit();
        for (int p = 0; p < 3; p++) if (e_v[p] != 0) m_ptr[p] = (e_id[p] + 1) % NT;
        m_debt = n_debt;
        m_alt = n_alt;
        m_cnt += e_stall;
    endtask

    // Called at a negedge with inputs set; returns at the next negedge.
    task automatic cycle();
        int act_v[3];
        int act_id[3];
        #1;
        model_eval();
        act_v[0] = int'(fp32_vld); act_v[1] = int'(int_vld); act_v[2] = int'(h16_vld);
        act_id[0] = int'(fp32_tid); act_id[1] = int'(int_tid); act_id[2] = int'(h16_tid);
        chk("R1 at most two issues", int'($countones({fp32_vld, int_vld, h16_vld}) <= 2), 1);
        for (int p = 0; p < 3; p++) begin
            if (act_v[p] != 0)
                chk("R2 granted thread ready with class",
                    int'(rdy[act_id[p]] && int'(cls[2*act_id[p] +: 2]) == p), 1);
        end
        chk("R4 wide float valid", act_v[0], e_v[0]);
        chk("R4 integer valid", act_v[1], e_v[1]);
        chk("R5 narrow valid", act_v[2], e_v[2]);
        for (int p = 0; p < 3; p++)
            if (e_v[p] != 0) chk("R4 rotating thread id", act_id[p], e_id[p]);
        chk("R8 stall pulse", int'(stall_pulse), e_stall);
        chk("R9 stall counter", int'(stall_count), m_cnt);
        @(posedge clk);
        model_commit();
        @(negedge clk);
    endtask

    function automatic logic [2*NT-1:0] all_cls(input logic [1:0] c);
        logic [2*NT-1:0] v;
        for (int t = 0; t < NT; t++) v[2*t +: 2] = c;
        return v;
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int pairs;
        for (int p = 0; p < 3; p++) m_ptr[p] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state with nothing ready
        #1;
        chk("R10 no issue after reset", int'(fp32_vld | int_vld | h16_vld | stall_pulse), 0);
        chk("R10 counter zero after reset", int'(stall_count), 0);
        @(negedge clk);

        // R6/R7: steady wide pair load, alternating classes
        for (int t = 0; t < NT; t++) cls[2*t +: 2] = (t % 2 == 0) ? 2'd0 : 2'd1;
        rdy = '1;
        pairs = 0;
        for (int c = 0; c < 8; c++) begin
            #1;
            if (c == 0) chk("R6 over-budget pair issues at zero debt", int'(fp32_vld && int_vld), 1);
            if (fp32_vld && int_vld) pairs++;
            #0;
            cycle();
        end
        chk("R7 three pairs per four cycles", pairs, 6);
        chk("R9 two throttled cycles counted", int'(stall_count), 2);

        // R3: class 2'b11 threads never issue
        cls = all_cls(2'd3);
        rdy = '1;
        for (int c = 0; c < 4; c++) begin
            #1;
            chk("R3 empty class ignored", int'(fp32_vld | int_vld | h16_vld), 0);
            cycle();
        end

        // R11: single class, every cycle issues
        cls = all_cls(2'd0);
        rdy = 8'b1010_0110;
        for (int c = 0; c < 6; c++) begin
            #1;
            chk("R11 single class issues each cycle", int'(fp32_vld), 1);
            cycle();
        end

        // R5: three-way contest, narrow always issues, wide pipes alternate
        for (int t = 0; t < NT; t++) cls[2*t +: 2] = 2'(t % 3);
        rdy = '1;
        for (int c = 0; c < 6; c++) cycle();

        // mixed random traffic
        for (int c = 0; c < 400; c++) begin
            rdy = NT'($urandom);
            for (int t = 0; t < NT; t++) cls[2*t +: 2] = 2'($urandom % 4);
            if (c % 50 < 20) begin
                for (int t = 0; t < NT; t++) if (cls[2*t +: 2] == 2'd2) cls[2*t +: 2] = 2'(t % 2);
            end
            cycle();
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule